// File: doc/BRIEF.md
# Multi-Channel Timer Compare Unit

This block watches a free-running time value supplied from outside and compares it against a programmed target in each of several independent channels (four by default). When the time value steps onto a channel's target while that channel is armed, the channel raises a sticky event flag and drives its output pin. In toggle mode the pin inverts. In pulse mode the pin is high for one clock. The flag can also drive a shared interrupt line and a per-channel DMA request, and each of these has its own enable bit.

Each compare target is double-buffered. While a channel is disarmed, a write to its compare register loads the live target directly. While the channel is armed, a write goes into a holding slot, and that slot is promoted to the live target at the next match. Software can therefore always keep one event queued ahead of the one pending. Flags are cleared by writing one to them. A read-only global status word mirrors all channel flags in one place.

Top module: `tcmp_bank`

## Requirements
- R1: After reset, every control word, every compare value and the global status word read 0, all pins are low, and irq and dma_req are 0.
- R2: Byte address 0x004 reads the global status word, with the flag of channel n in bit n; writes to it are ignored. Channel n has its control word at 0x008+8n and its compare value at 0x00C+8n. The control word holds: bit 0 DMA enable, bits [5:2] mode, bit 6 interrupt enable, bit 7 event flag; bit 1 reads 0. Any other address reads 0.
- R3: A match occurs in a cycle where the mode is non-zero, time_in equals the live compare value, and time_in in the previous cycle was different. The flag is set at the clock edge that ends that cycle. Holding time_in on the target does not match again.
- R4: With mode 0, no match occurs and the pin holds its level. Writing 0 to the control word disarms the channel. A non-zero mode other than 0x5 or 0xF sets the flag on a match and leaves the pin unchanged.
- R5: Mode 0x5 inverts the channel pin at each match. The pin level is registered and starts low.
- R6: Mode 0xF drives the pin high for exactly the one cycle after a match and low otherwise.
- R7: Writing 1 to flag bit 7 clears the flag, and writing 0 to it leaves the flag unchanged. If a clear and a match fall in the same cycle, the flag ends up set.
- R8: A compare write while the mode is 0 loads the live value and discards any queued value. A compare write while the mode is non-zero queues the value. At a match, a queued value becomes live. The compare register reads back the live value.
- R9: irq is the OR over channels of flag AND interrupt enable, and dma_req[n] is the flag of channel n AND its DMA enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_in | input | CNT_W | Shared time value being compared |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational on bus_addr |
| ch_out | output | NUM_CH | Per-channel output pins |
| dma_req | output | NUM_CH | Per-channel DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every channel through toggle, pulse and flag-only modes and checks pin, flag, status, irq and dma_req on the exact cycle after the target is reached. A design that matched on level rather than on transition would re-raise a flag that was just cleared while time holds on the target. A design that stretched the pulse would leave the pin high on the second cycle. The double buffer is exercised by queuing a second target behind a live one, checking that the readback swaps only at the match, and checking that a disarmed write discards the queue. A design that wrote straight through would read back the wrong target or miss the second event. The bench also lines up a flag clear with a match in the same cycle, and a clear that lost to the match would leave the event unreported.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  typedef struct packed {
    logic       flag;   // bit 7
    logic       ie;     // bit 6
    logic [3:0] mode;   // bits 5:2
    logic       rsv;    // bit 1
    logic       dma;    // bit 0
  } ctl_word_t;

endpackage

// File: rtl/tcmp_compare.sv
module tcmp_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] time_now_i,
  input  logic [CNT_W-1:0] time_prev_i,
  output logic [CNT_W-1:0] live_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] live_q, live_d;
  logic [CNT_W-1:0] queue_q, queue_d;
  logic             qvalid_q, qvalid_d;

  assign hit_o  = armed_i && (time_now_i == live_q) && (time_prev_i != live_q);
  assign live_o = live_q;

  always_comb begin
    live_d   = live_q;
    queue_d  = queue_q;
    qvalid_d = qvalid_q;
    if (hit_o && qvalid_q) begin
      live_d   = queue_q;
      qvalid_d = 1'b0;
    end
    if (wr_i) begin
      if (!armed_i) begin
        live_d   = wdata_i;
        qvalid_d = 1'b0;
      end else begin
        queue_d  = wdata_i;
        qvalid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      queue_q  <= '0;
      qvalid_q <= 1'b0;
    end else begin
      live_q   <= live_d;
      queue_q  <= queue_d;
      qvalid_q <= qvalid_d;
    end
  end

  // R8: a queued value is promoted at a match
  assert_queue_promote_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && qvalid_q && !wr_i) |=> (live_q == $past(queue_q) && !qvalid_q));

  // R8: a disarmed write discards the queue
  assert_disarmed_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !armed_i) |=> (!qvalid_q && live_q == $past(wdata_i)));

endmodule

// File: rtl/tcmp_ctrl.sv
module tcmp_ctrl
  import tcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       w_dma_i,
  input  logic [3:0] w_mode_i,
  input  logic       w_ie_i,
  input  logic       w_clr_i,
  input  logic       hit_i,
  output ctl_word_t  ctl_o,
  output logic       pin_o,
  output logic       irq_o,
  output logic       dma_o
);

  logic       dma_q, dma_d;
  logic       ie_q, ie_d;
  logic [3:0] mode_q, mode_d;
  logic       flag_q, flag_d;
  logic       pin_q, pin_d;

  always_comb begin
    dma_d  = dma_q;
    ie_d   = ie_q;
    mode_d = mode_q;
    flag_d = flag_q;
    if (wr_i) begin
      dma_d  = w_dma_i;
      ie_d   = w_ie_i;
      mode_d = w_mode_i;
      if (w_clr_i) flag_d = 1'b0;
    end
    if (hit_i) flag_d = 1'b1;
  end

  always_comb begin
    case (mode_q)
      MODE_TOGGLE: pin_d = hit_i ? ~pin_q : pin_q;
      MODE_PULSE:  pin_d = hit_i;
      default:     pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q  <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= MODE_OFF;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      dma_q  <= dma_d;
      ie_q   <= ie_d;
      mode_q <= mode_d;
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  assign ctl_o = '{flag: flag_q, ie: ie_q, mode: mode_q, rsv: 1'b0, dma: dma_q};
  assign pin_o = pin_q;
  assign irq_o = flag_q & ie_q;
  assign dma_o = flag_q & dma_q;

  // R3: the flag only rises after a match
  assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit_i));

  // R7: a match always leaves the flag set, clear or not
  assert_match_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_q);

  // R4: a disarmed channel sees no match
  assert_off_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> !hit_i);

  // R5: toggle mode inverts the pin at a match
  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TOGGLE && hit_i) |=> (pin_q != $past(pin_q)));

  // R6: pulse mode pin is low after any non-match cycle
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PULSE && !hit_i) |=> !pin_q);

endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank
  import tcmp_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int STAT_OFS  = 4,
  parameter int CH_BASE   = 8,
  parameter int CH_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  time_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] ch_out,
  output logic [NUM_CH-1:0] dma_req,
  output logic              irq
);

  localparam int CMP_OFS = CH_STRIDE / 2;
  localparam int CTL_W   = $bits(ctl_word_t);

  logic [CNT_W-1:0]             time_prev_q;
  ctl_word_t [NUM_CH-1:0]       ctl_rd;
  logic [NUM_CH-1:0][CNT_W-1:0] live_rd;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            ch_irq;
  logic [NUM_CH-1:0]            flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_prev_q <= '0;
    else        time_prev_q <= time_in;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_ctl, wr_cmp, armed;
    assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(CH_BASE + g * CH_STRIDE));
    assign wr_cmp = bus_wr && (bus_addr == ADDR_W'(CH_BASE + g * CH_STRIDE + CMP_OFS));
    assign armed  = (ctl_rd[g].mode != MODE_OFF);

    tcmp_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (wr_cmp),
      .wdata_i     (bus_wdata[CNT_W-1:0]),
      .armed_i     (armed),
      .time_now_i  (time_in),
      .time_prev_i (time_prev_q),
      .live_o      (live_rd[g]),
      .hit_o       (hit[g])
    );

    tcmp_ctrl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_ctl),
      .w_dma_i  (bus_wdata[0]),
      .w_mode_i (bus_wdata[5:2]),
      .w_ie_i   (bus_wdata[6]),
      .w_clr_i  (bus_wdata[7]),
      .hit_i    (hit[g]),
      .ctl_o    (ctl_rd[g]),
      .pin_o    (ch_out[g]),
      .irq_o    (ch_irq[g]),
      .dma_o    (dma_req[g])
    );

    assign flags[g] = ctl_rd[g].flag;
  end

  assign irq = |ch_irq;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(STAT_OFS)) bus_rdata = DATA_W'(flags);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE))
        bus_rdata = DATA_W'(ctl_rd[i]);
      if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + CMP_OFS))
        bus_rdata = DATA_W'(live_rd[i]);
    end
  end

  initial begin
    assert_params_R2: assert (CNT_W <= DATA_W && CTL_W <= DATA_W && CMP_OFS >= 1);
  end

endmodule

// File: tb/sim_tcmp_bank.sv
module sim_tcmp_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] time_in;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  ch_out;
  logic [3:0]  dma_req;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tcmp_bank u0 (
    .clk(clk), .rst_n(rst_n), .time_in(time_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_out(ch_out), .dma_req(dma_req), .irq(irq)
  );

  function automatic logic [11:0] ctla(int ch); return 12'(8 + 8 * ch);  endfunction
  function automatic logic [11:0] cmpa(int ch); return 12'(12 + 8 * ch); endfunction
  function automatic logic [31:0] cw(bit clr, bit ie, logic [3:0] mode, bit dma);
    return {24'b0, clr, ie, mode, 1'b0, dma};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] t);
    time_in = t;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        p;
    logic [3:0]  modes [3];
    modes[0] = 4'h5; modes[1] = 4'hF; modes[2] = 4'h3;
    rst_n = 1'b0; time_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < 4; ch++) begin
      rd(ctla(ch), d); chk("R1 ctl reset", d, 0);
      rd(cmpa(ch), d); chk("R1 cmp reset", d, 0);
    end
    rd(12'h004, d); chk("R1 status reset", d, 0);
    chk("R1 pins/irq/dma", {23'b0, irq, dma_req, ch_out}, 0);

    // R2 unmapped address and read-only status
    rd(12'h100, d); chk("R2 unmapped read", d, 0);

    // Sweep: every channel, every mode (R3 R5 R6 R4 R9 R2 R7)
    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 0; m < 3; m++) begin
        logic [31:0] c;
        c = 32'(1000 + ch * 64 + m * 8);
        wr(ctla(ch), 32'h80);
        wr(cmpa(ch), c);
        step(c - 2);
        wr(ctla(ch), cw(0, 1, modes[m], 1));
        rd(ctla(ch), d); chk("R2 ctl readback", d, cw(0, 1, modes[m], 1));
        step(c - 1);
        p = ch_out[ch];
        rd(12'h004, d); chk("R3 no early flag", d, 0);
        step(c);
        rd(12'h004, d); chk("R3 R2 status bit", d, 32'(1) << ch);
        chk("R9 irq", {31'b0, irq}, 1);
        chk("R9 dma", {28'b0, dma_req}, 32'(1) << ch);
        if (modes[m] == 4'h5)      chk("R5 toggle", {31'b0, ch_out[ch]}, {31'b0, ~p});
        else if (modes[m] == 4'hF) chk("R6 pulse high", {31'b0, ch_out[ch]}, 1);
        else                       chk("R4 other mode holds pin", {31'b0, ch_out[ch]}, {31'b0, p});
        step(c);
        if (modes[m] == 4'h5)      chk("R5 no second toggle", {31'b0, ch_out[ch]}, {31'b0, ~p});
        else if (modes[m] == 4'hF) chk("R6 pulse one cycle", {31'b0, ch_out[ch]}, 0);
        else                       chk("R4 pin still held", {31'b0, ch_out[ch]}, {31'b0, p});
        wr(ctla(ch), cw(1, 1, modes[m], 1));
        rd(12'h004, d); chk("R7 w1c clears", d, 0);
        chk("R9 irq low", {31'b0, irq}, 0);
        step(c);
        rd(12'h004, d); chk("R3 hold no rematch", d, 0);
      end
      wr(ctla(ch), 32'h80);
    end

    // R4 mode 0 never matches
    wr(cmpa(3), 32'd3000);
    p = ch_out[3];
    step(32'd2999); step(32'd3000);
    rd(12'h004, d); chk("R4 mode0 no flag", d, 0);
    chk("R4 mode0 pin", {31'b0, ch_out[3]}, {31'b0, p});

    // R9 enables off: flag set, no irq or dma
    wr(cmpa(2), 32'd4000);
    wr(ctla(2), cw(0, 0, 4'h5, 0));
    step(32'd3999); step(32'd4000);
    rd(12'h004, d); chk("R9 flag without enables", d, 32'h4);
    chk("R9 irq masked", {31'b0, irq}, 0);
    chk("R9 dma masked", {28'b0, dma_req}, 0);
    // R2 writes to status are ignored
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R2 status read-only", d, 32'h4);
    // R7 writing 0 to flag keeps it
    wr(ctla(2), cw(0, 0, 4'h5, 0));
    rd(12'h004, d); chk("R7 write0 keeps flag", d, 32'h4);
    wr(ctla(2), 32'h80);

    // R7 clear and match in the same cycle
    wr(cmpa(1), 32'd500);
    wr(ctla(1), cw(0, 1, 4'h5, 0));
    step(32'd499); step(32'd500);
    rd(12'h004, d); chk("R7 first match", d, 32'h2);
    step(32'd499);
    p = ch_out[1];
    time_in = 32'd500;
    wr(ctla(1), cw(1, 1, 4'h5, 0));
    rd(12'h004, d); chk("R7 match beats clear", d, 32'h2);
    chk("R5 toggle on simultaneous", {31'b0, ch_out[1]}, {31'b0, ~p});
    wr(ctla(1), 32'h80);

    // R8 double buffer
    wr(cmpa(0), 32'd100);
    wr(ctla(0), cw(0, 0, 4'h5, 0));
    wr(cmpa(0), 32'd200);
    rd(cmpa(0), d); chk("R8 live before match", d, 32'd100);
    step(32'd99); step(32'd100);
    rd(cmpa(0), d); chk("R8 queue promoted", d, 32'd200);
    wr(ctla(0), cw(1, 0, 4'h5, 0));
    step(32'd150);
    rd(12'h004, d); chk("R8 no event between", d, 0);
    step(32'd200);
    rd(12'h004, d); chk("R8 second event", d, 32'h1);
    wr(ctla(0), cw(1, 0, 4'h5, 0));
    wr(cmpa(0), 32'd300);
    wr(ctla(0), 32'h0);
    wr(cmpa(0), 32'd50);
    wr(ctla(0), cw(0, 0, 4'h5, 0));
    rd(cmpa(0), d); chk("R8 disarmed load", d, 32'd50);
    step(32'd299); step(32'd300);
    rd(12'h004, d); chk("R8 discarded queue no match", d, 0);
    step(32'd49); step(32'd50);
    rd(12'h004, d); chk("R8 direct target matches", d, 32'h1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule